// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is a three-wire serial slave. A microcontroller uses it to load a 32-bit setup word into a fractional-N clock synthesizer. The three lines are an active-high select, a serial clock and a data line. They arrive asynchronously, so each one passes through a two-flop synchronizer into the system clock domain. The block samples one data bit on each synchronized rising edge of the serial clock, but only while select is high.

When select falls, the block checks the frame. A good frame has exactly 32 bits, a zero preamble, a zero reserved field, and a legal sum of the two fraction counts. If the frame is good, its fields are copied into registered outputs and a one-cycle acquire pulse tells the synthesizer to start locking. A frame that fails any check leaves the outputs unchanged and sets an error flag.

A select pulse with no serial clocks restarts acquisition on the settings already held. The block also reports how many bits the current or last frame contained.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the outputs are qp_o=1, qpm1_o=0, divsel_o=7, postdiv_o=0, ndiv_o=5, mdiv_o=5, acquire_o=0, frame_error_o=0 and bit_count_o=0.
- R2: While select is high, each rising edge of the serial clock shifts in one data bit and adds one to bit_count_o. A rising edge of select clears bit_count_o to zero.
- R3: While select is low, serial clock edges and data changes have no effect on bit_count_o or on any output field.
- R4: The bits are sent most significant bit first, in this order: preamble (4 bits), qp (5), qpm1 (5), divsel (4), reserved (3), postdiv (5), ndiv (3), mdiv (3). The first bit sent is word bit 31.
- R5: On the falling edge of select, a frame is accepted only if all of these hold: it has exactly 32 bits, the preamble is 0000, the reserved field is 000, and qp+qpm1 is between 1 and 31. An accepted frame loads all six fields within three system clocks.
- R6: A frame with any bit count other than 0 or 32 is dropped: the fields keep their values and frame_error_o is set.
- R7: A 32-bit frame is rejected, with frame_error_o set, if its preamble is not 0000 or its reserved field is not 000.
- R8: A 32-bit frame is rejected, with frame_error_o set, if qp+qpm1 is 0 or more than 31. A sum of exactly 31 is accepted.
- R9: acquire_o is high for exactly one system clock for each accepted frame, including a frame that repeats the word already loaded, and never for a rejected frame.
- R10: A select pulse with no serial clock edges gives one acquire pulse, leaves the fields unchanged and clears frame_error_o.
- R11: frame_error_o stays set until the next accepted frame or restart pulse, which clears it.
- R12: bit_count_o saturates at 63 when a frame is longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_in | input | 1 | Asynchronous select, active high |
| sclk_in | input | 1 | Asynchronous serial clock |
| sdata_in | input | 1 | Asynchronous serial data |
| qp_o | output | 5 | Count of cycles that divide by P |
| qpm1_o | output | 5 | Count of cycles that divide by P-1 |
| divsel_o | output | 4 | Integer divider select |
| postdiv_o | output | 5 | Output post-divider select |
| ndiv_o | output | 3 | Ratio numerator select |
| mdiv_o | output | 3 | Ratio denominator select |
| acquire_o | output | 1 | One-cycle pulse that starts frequency acquisition |
| frame_error_o | output | 1 | Last frame was rejected |
| bit_count_o | output | 6 | Bits received in the current or last frame |

## Verification
The assertions take three things for granted about the inputs. The serial clock is much slower than the system clock. Data is stable for several system clocks around each serial rising edge. Select changes only while the serial clock is low. Under those conditions, the synchronized copies of the data and clock lines stay aligned, and no sample lands in the same cycle as a select edge. The stimulus keeps every serial level for four system clocks, changes data only while the serial clock is low, and leaves four-clock gaps on each side of every select edge.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int PRE_W  = 4;
  localparam int QP_W   = 5;
  localparam int DIV_W  = 4;
  localparam int RSV_W  = 3;
  localparam int POST_W = 5;
  localparam int ND_W   = 3;
  localparam int MD_W   = 3;

  localparam int MD_LSB   = 0;
  localparam int ND_LSB   = MD_LSB + MD_W;
  localparam int POST_LSB = ND_LSB + ND_W;
  localparam int RSV_LSB  = POST_LSB + POST_W;
  localparam int DIV_LSB  = RSV_LSB + RSV_W;
  localparam int QPM1_LSB = DIV_LSB + DIV_W;
  localparam int QP_LSB   = QPM1_LSB + QP_W;
  localparam int PRE_LSB  = QP_LSB + QP_W;
  localparam int WORD_W   = PRE_LSB + PRE_W;
  localparam int QSUM_MAX = (1 << QP_W) - 1;

  typedef struct packed {
    logic [QP_W-1:0]   qp;
    logic [QP_W-1:0]   qpm1;
    logic [DIV_W-1:0]  divsel;
    logic [POST_W-1:0] postdiv;
    logic [ND_W-1:0]   ndiv;
    logic [MD_W-1:0]   mdiv;
  } synth_cfg_t;

  localparam synth_cfg_t CFG_RESET = '{qp: 5'd1, qpm1: 5'd0, divsel: 4'd7,
                                       postdiv: 5'd0, ndiv: 3'd5, mdiv: 3'd5};

  function automatic synth_cfg_t decode_word(input logic [WORD_W-1:0] w);
    synth_cfg_t c;
    c.qp      = w[QP_LSB   +: QP_W];
    c.qpm1    = w[QPM1_LSB +: QP_W];
    c.divsel  = w[DIV_LSB  +: DIV_W];
    c.postdiv = w[POST_LSB +: POST_W];
    c.ndiv    = w[ND_LSB   +: ND_W];
    c.mdiv    = w[MD_LSB   +: MD_W];
    return c;
  endfunction

  function automatic logic word_legal(input logic [WORD_W-1:0] w);
    logic [QP_W:0] qsum;
    qsum = {1'b0, w[QP_LSB +: QP_W]} + {1'b0, w[QPM1_LSB +: QP_W]};
    return (w[PRE_LSB +: PRE_W] == '0) && (w[RSV_LSB +: RSV_W] == '0) &&
           (qsum != '0) && (int'(qsum) <= QSUM_MAX);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count,
  output logic              frame_end
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cs_d, sclk_d;
  logic sample, cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign sample    = cs_s && sclk_s && !sclk_d;
  assign cs_rise   = cs_s && !cs_d;
  assign frame_end = cs_d && !cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      count <= '0;
    end else begin
      if (sample) word <= {word[WORD_W-2:0], sdata_s};
      if (cs_rise)
        count <= sample ? CNT_W'(1) : '0;
      else if (sample && count != CNT_MAX)
        count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfgport_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  count,
  output synth_cfg_t        cfg,
  output logic              acquire,
  output logic              frame_error
);
  logic restart, full, accept;

  assign restart = frame_end && (count == '0);
  assign full    = frame_end && (int'(count) == WORD_W);
  assign accept  = full && word_legal(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg         <= CFG_RESET;
      acquire     <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      acquire <= accept || restart;
      if (accept) cfg <= decode_word(word);
      if (frame_end) frame_error <= !(accept || restart);
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_in,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic [QP_W-1:0]   qp_o,
  output logic [QP_W-1:0]   qpm1_o,
  output logic [DIV_W-1:0]  divsel_o,
  output logic [POST_W-1:0] postdiv_o,
  output logic [ND_W-1:0]   ndiv_o,
  output logic [MD_W-1:0]   mdiv_o,
  output logic              acquire_o,
  output logic              frame_error_o,
  output logic [CNT_W-1:0]  bit_count_o
);
  logic [2:0]        raw_lines, sync_lines;
  logic              cs_s, sclk_s, sdata_s;
  logic [WORD_W-1:0] word;
  logic              frame_end;
  synth_cfg_t        cfg;

  assign raw_lines = {cs_in, sclk_in, sdata_in};
  assign {cs_s, sclk_s, sdata_s} = sync_lines;

  cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst(rst), .d(raw_lines), .q(sync_lines));

  cfg_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .sdata_s(sdata_s),
    .word(word), .count(bit_count_o), .frame_end(frame_end));

  cfg_commit #(.CNT_W(CNT_W)) u_commit (
    .clk(clk), .rst(rst), .frame_end(frame_end), .word(word),
    .count(bit_count_o), .cfg(cfg), .acquire(acquire_o),
    .frame_error(frame_error_o));

  assign qp_o      = cfg.qp;
  assign qpm1_o    = cfg.qpm1;
  assign divsel_o  = cfg.divsel;
  assign postdiv_o = cfg.postdiv;
  assign ndiv_o    = cfg.ndiv;
  assign mdiv_o    = cfg.mdiv;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_s,
  input logic [4:0]       qp_o,
  input logic [4:0]       qpm1_o,
  input logic [26:0]      fields,
  input logic             acquire_o,
  input logic             frame_error_o,
  input logic [CNT_W-1:0] bit_count_o
);
  AST_ACQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    acquire_o |=> !acquire_o);                                            // R9
  AST_ACQ_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    acquire_o |-> !frame_error_o);                                        // R11
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acquire_o |-> $stable(fields));                                      // R5
  AST_QSUM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    acquire_o |-> ((qp_o + 6'd0 + qpm1_o) != 0 && (qp_o + 6'd0 + qpm1_o) <= 31)); // R8
  AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> $stable(bit_count_o));                                      // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_count_o) |-> (bit_count_o <= 1 ||
                               bit_count_o == $past(bit_count_o) + 1'b1)); // R2
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .qp_o(qp_o), .qpm1_o(qpm1_o),
  .fields({qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o}),
  .acquire_o(acquire_o), .frame_error_o(frame_error_o),
  .bit_count_o(bit_count_o));

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 4;

  logic clk = 0, rst = 1, cs_in = 0, sclk_in = 0, sdata_in = 0;
  logic [4:0] qp_o, qpm1_o, postdiv_o;
  logic [3:0] divsel_o;
  logic [2:0] ndiv_o, mdiv_o;
  logic acquire_o, frame_error_o;
  logic [5:0] bit_count_o;

  int checks = 0, fails = 0, acq_cnt = 0, acq_run = 0;
  bit prev_acq = 0, done = 0;
  logic [26:0] cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst(rst), .cs_in(cs_in), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .qp_o(qp_o), .qpm1_o(qpm1_o), .divsel_o(divsel_o), .postdiv_o(postdiv_o),
    .ndiv_o(ndiv_o), .mdiv_o(mdiv_o), .acquire_o(acquire_o),
    .frame_error_o(frame_error_o), .bit_count_o(bit_count_o));

  always @(negedge clk) begin
    if (acquire_o) acq_cnt++;
    if (acquire_o && prev_acq) acq_run++;
    prev_acq = acquire_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] pre, input logic [4:0] qp,
      input logic [4:0] qm, input logic [3:0] dv, input logic [2:0] rs,
      input logic [4:0] pd, input logic [2:0] n, input logic [2:0] m);
    return {pre, qp, qm, dv, rs, pd, n, m};
  endfunction

  function automatic logic [26:0] flds(input logic [31:0] w);
    return {w[27:18], w[17:14], w[10:0]};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // sends nbits; bits beyond 32 are zeros, first bit is w[31]
  task automatic send(input logic [31:0] w, input int nbits);
    acq_cnt = 0; acq_run = 0;
    cs_in = 1; wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdata_in = (i < 32) ? w[31-i] : 1'b0;
      wclk(HALF); sclk_in = 1; wclk(HALF); sclk_in = 0;
    end
    wclk(HALF); cs_in = 0; wclk(8);
    cur = {qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o};
  endtask

  task automatic expect_accept(input string req, input logic [31:0] w);
    check(cur == flds(w), req, cur, flds(w));
    check(acq_cnt == 1 && acq_run == 0, {req, " acquire"}, acq_cnt, 1);
    check(!frame_error_o, {req, " error"}, frame_error_o, 0);
  endtask

  task automatic expect_reject(input string req, input logic [26:0] keep);
    check(cur == keep, req, cur, keep);
    check(acq_cnt == 0, {req, " acquire"}, acq_cnt, 0);
    check(frame_error_o, {req, " error"}, frame_error_o, 1);
  endtask

  logic [31:0] wa, wb;

  task automatic t_reset();
    check({qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o} ==
          {5'd1, 5'd0, 4'd7, 5'd0, 3'd5, 3'd5}, "R1 fields",
          {qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o}, 0);
    check(!acquire_o && !frame_error_o && bit_count_o == 0, "R1 flags",
          {acquire_o, frame_error_o, bit_count_o}, 0);
  endtask

  task automatic t_accept_two();
    send(wa, 32); expect_accept("R5 R4 pattern A", wa);
    check(bit_count_o == 32, "R2 count", bit_count_o, 32);
    send(wb, 32); expect_accept("R4 pattern B", wb);
  endtask

  task automatic t_repeat();
    send(wb, 32); expect_accept("R9 same word", wb);
  endtask

  task automatic t_cs_low();
    acq_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      sdata_in = i[0]; wclk(HALF); sclk_in = 1; wclk(HALF); sclk_in = 0;
    end
    wclk(8);
    check(bit_count_o == 32, "R3 count", bit_count_o, 32);
    check({qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o} == flds(wb) && acq_cnt == 0,
          "R3 fields", {qp_o, qpm1_o, divsel_o, postdiv_o, ndiv_o, mdiv_o}, flds(wb));
  endtask

  task automatic t_bad_counts();
    send(wa, 31); expect_reject("R6 short", flds(wb));
    check(bit_count_o == 31, "R6 count", bit_count_o, 31);
    send(wa, 32); expect_accept("R11 clear", wa);
    send(wb, 33); expect_reject("R6 long", flds(wa));
  endtask

  task automatic t_bad_fixed();
    send(mk(4'b0100, 5'd2, 5'd3, 4'd1, 3'd0, 5'd1, 3'd1, 3'd1), 32);
    expect_reject("R7 preamble", flds(wa));
    send(mk(4'b0000, 5'd2, 5'd3, 4'd1, 3'd4, 5'd1, 3'd1, 3'd1), 32);
    expect_reject("R7 reserved", flds(wa));
  endtask

  task automatic t_qsum();
    logic [31:0] w31;
    send(mk(4'd0, 5'd0, 5'd0, 4'd3, 3'd0, 5'd2, 3'd2, 3'd2), 32);
    expect_reject("R8 zero sum", flds(wa));
    send(mk(4'd0, 5'd16, 5'd16, 4'd3, 3'd0, 5'd2, 3'd2, 3'd2), 32);
    expect_reject("R8 sum 32", flds(wa));
    w31 = mk(4'd0, 5'd31, 5'd0, 4'd15, 3'd0, 5'd31, 3'd7, 3'd0);
    send(w31, 32); expect_accept("R8 sum 31", w31);
    wa = w31;
  endtask

  task automatic t_restart();
    send(wb, 40); expect_reject("R6 pre-restart", flds(wa));
    send(32'h0, 0);
    check(cur == flds(wa), "R10 fields", cur, flds(wa));
    check(acq_cnt == 1 && acq_run == 0, "R10 acquire", acq_cnt, 1);
    check(!frame_error_o, "R10 error", frame_error_o, 0);
  endtask

  task automatic t_saturate();
    send(wb, 70); expect_reject("R12 long", flds(wa));
    check(bit_count_o == 63, "R12 count", bit_count_o, 63);
  endtask

  initial begin
    wa = mk(4'd0, 5'd1, 5'd24, 4'd7, 3'd0, 5'd12, 3'd5, 3'd5);
    wb = mk(4'd0, 5'd11, 5'd7, 4'd9, 3'd0, 5'd28, 3'd2, 3'd6);
    wclk(5); rst = 0; wclk(3);
    t_reset();
    t_accept_two();
    t_repeat();
    t_cs_low();
    t_bad_counts();
    t_bad_fixed();
    t_qsum();
    t_restart();
    t_saturate();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule